// File: doc/BRIEF.md
# Sequential Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision binary floating-point words (1 sign bit, 8 exponent bits biased by 127, 23 fraction bits) over several clock cycles. A one-cycle `start` pulse captures both operands and the operation select. The block then steps through a fixed order of phases. It checks for zero operands first. It then lines up the significands one bit per cycle and adds them as sign-magnitude values. After that it renormalises one bit per cycle and rounds. A single-cycle `done` pulse marks the point where `z_out` and the two flags hold the new result. They keep that value until the next operation completes.

Subtraction flips the sign of the second operand on capture and then takes the same path as addition. Each significand is held as the hidden one, the fraction and three extra low guard bits. An exponent field of zero counts as a zero operand. Infinities, NaNs and denormal inputs are not handled.

Top module: `fp_addsub_seq`

## Requirements
- R1: After reset, `done`, `ovf`, `unf` and `z_out` are all zero.
- R2: With `op_sub`=1 the result equals the addition of X and Y with bit 31 of Y inverted.
- R3: If the exponent field (bits 30:23) of X is zero, `z_out` is Y with its sign adjusted for the operation. Otherwise, if the exponent field of Y is zero, `z_out` is X. In both cases `done` rises in the second cycle after the start is sampled.
- R4: The operand with the smaller exponent is shifted right one bit per cycle, and its exponent grows by one each time. If an exponent gap of 27 or more shifts that significand to zero, `z_out` is the other operand unchanged (Y with its adjusted sign).
- R5: The significands are combined by sign: equal signs add, and unequal signs subtract the smaller magnitude from the larger, taking that operand's sign. A zero sum gives +0 (0x00000000) with both flags clear.
- R6: A carry out of the sum shifts the significand right once and raises the exponent by one. If the exponent reaches 255 here or after rounding, `ovf` is set and `z_out` is the signed infinity pattern (exponent 255, fraction 0).
- R7: Normalisation shifts left one bit per cycle and lowers the exponent by one each time, until the hidden-bit position holds 1. If a shift would bring the exponent to 0, it stops, `unf` is set and `z_out` is a signed zero.
- R8: Rounding uses the three guard bits and rounds half up. A carry out of the 24-bit significand gives fraction 0 with the exponent raised by one.
- R9: Results use a bias of 127, so 40.0 + 7.625 gives 0x423E8000 (sign 0, exponent 132, fraction 0x3E8000).
- R10: A `start` that arrives while an operation is in progress is ignored. The running result is unchanged and no extra `done` follows.
- R11: `done` is high for exactly one cycle per operation, and `ovf` and `unf` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_sub | input | 1 | 1 selects X - Y, 0 selects X + Y |
| x_in | input | 32 | Operand X |
| y_in | input | 32 | Operand Y |
| z_out | output | 32 | Result word |
| done | output | 1 | One-cycle result-valid pulse |
| ovf | output | 1 | Exponent overflow on the last result |
| unf | output | 1 | Exponent underflow on the last result |

## Verification
The bench builds the block with its default widths: 8 exponent bits, 23 fraction bits and 3 guard bits. With these widths a 27-bit exponent gap is the exact point where alignment loses the smaller operand. Operands near 2^-125 reach the underflow stop in two left shifts. Adding the largest finite values reaches overflow, and 1.0 plus 2^-24 lands exactly on the half-up rounding tie.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_ALIGN, ST_ADD, ST_NORM, ST_ROUND, ST_FIN
  } fpas_state_e;
endpackage

// File: rtl/fpas_align_step.sv
module fpas_align_step #(
  parameter int EW = 9,
  parameter int SW = 27
) (
  input  logic [EW-1:0] ea,
  input  logic [EW-1:0] eb,
  input  logic [SW-1:0] ma,
  input  logic [SW-1:0] mb,
  output logic          same_exp,
  output logic          a_smaller,
  output logic [SW-1:0] shifted,
  output logic [EW-1:0] bumped,
  output logic          lost
);
  function automatic logic [SW-1:0] shr1(input logic [SW-1:0] v);
    return v >> 1;
  endfunction

  always_comb begin
    same_exp  = (ea == eb);
    a_smaller = (ea < eb);
    shifted   = shr1(a_smaller ? ma : mb);
    bumped    = (a_smaller ? ea : eb) + EW'(1);
    lost      = (shifted == '0);
  end
endmodule

// File: rtl/fpas_sigadd.sv
module fpas_sigadd #(
  parameter int SW = 27
) (
  input  logic          sa,
  input  logic [SW-1:0] ma,
  input  logic          sb,
  input  logic [SW-1:0] mb,
  output logic          s_sign,
  output logic [SW:0]   s_mag
);
  function automatic logic [SW:0] mag_combine(input logic same, input logic [SW-1:0] a,
                                              input logic [SW-1:0] b);
    if (same)        return {1'b0, a} + {1'b0, b};
    else if (a >= b) return {1'b0, a - b};
    else             return {1'b0, b - a};
  endfunction

  always_comb begin
    s_mag  = mag_combine(sa == sb, ma, mb);
    s_sign = (sa == sb || ma >= mb) ? sa : sb;
  end
endmodule

// File: rtl/fpas_round_pack.sv
module fpas_round_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRD    = 3
) (
  input  logic                    sign,
  input  logic [EXP_W:0]          e,
  input  logic [FRAC_W+GRD:0]     sig,
  output logic [EXP_W+FRAC_W:0]   word,
  output logic                    ovf
);
  localparam int EW   = EXP_W + 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic [GRD-1:0] HALF = GRD'(1) << (GRD - 1);

  logic [FRAC_W:0]   mant;
  logic              up;
  logic              carry;
  logic [FRAC_W-1:0] frac;
  logic [EW-1:0]     e2;

  function automatic logic half_up(input logic [GRD-1:0] g);
    return g >= HALF;
  endfunction

  always_comb begin
    mant  = sig[FRAC_W+GRD:GRD];
    up    = half_up(sig[GRD-1:0]);
    carry = (&mant) & up;
    frac  = mant[FRAC_W-1:0] + FRAC_W'(up);
    e2    = e + EW'(carry);
    ovf   = (e2 == EW'(EMAX));
    if (ovf) word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else     word = {sign, e2[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fp_addsub_seq.sv
module fp_addsub_seq
  import fpas_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRD    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        op_sub,
  input  logic [EXP_W+FRAC_W:0]       x_in,
  input  logic [EXP_W+FRAC_W:0]       y_in,
  output logic [EXP_W+FRAC_W:0]       z_out,
  output logic                        done,
  output logic                        ovf,
  output logic                        unf
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SW     = 1 + FRAC_W + GRD;
  localparam int EW     = EXP_W + 1;
  localparam int EMAX   = (1 << EXP_W) - 1;

  fpas_state_e       st;
  logic              sa, sb, rs;
  logic [EW-1:0]     ea, eb, re;
  logic [SW-1:0]     ma, mb, rsig;
  logic [WORD_W-1:0] xw, yw;

  // named events for the checker
  logic zero_hit, align_step, norm_step;

  logic          al_same, al_a_small, al_lost;
  logic [SW-1:0] al_shifted;
  logic [EW-1:0] al_bumped;
  logic          ad_sign;
  logic [SW:0]   ad_mag;
  logic [WORD_W-1:0] rp_word;
  logic          rp_ovf;

  fpas_align_step #(.EW(EW), .SW(SW)) i_align (
    .ea(ea), .eb(eb), .ma(ma), .mb(mb),
    .same_exp(al_same), .a_smaller(al_a_small),
    .shifted(al_shifted), .bumped(al_bumped), .lost(al_lost)
  );

  fpas_sigadd #(.SW(SW)) i_add (
    .sa(sa), .ma(ma), .sb(sb), .mb(mb), .s_sign(ad_sign), .s_mag(ad_mag)
  );

  fpas_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRD(GRD)) i_round (
    .sign(rs), .e(re), .sig(rsig), .word(rp_word), .ovf(rp_ovf)
  );

  assign zero_hit   = (st == ST_CHECK) && ((ea == '0) || (eb == '0));
  assign align_step = (st == ST_ALIGN) && !al_same;
  assign norm_step  = (st == ST_NORM) && !rsig[SW-1] && (re != EW'(1));
  assign done       = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      sa <= 1'b0; sb <= 1'b0; rs <= 1'b0;
      ea <= '0; eb <= '0; re <= '0;
      ma <= '0; mb <= '0; rsig <= '0;
      xw <= '0; yw <= '0;
      z_out <= '0; ovf <= 1'b0; unf <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          sa <= x_in[WORD_W-1];
          sb <= y_in[WORD_W-1] ^ op_sub;
          ea <= {1'b0, x_in[WORD_W-2:FRAC_W]};
          eb <= {1'b0, y_in[WORD_W-2:FRAC_W]};
          ma <= {1'b1, x_in[FRAC_W-1:0], {GRD{1'b0}}};
          mb <= {1'b1, y_in[FRAC_W-1:0], {GRD{1'b0}}};
          xw <= x_in;
          yw <= {y_in[WORD_W-1] ^ op_sub, y_in[WORD_W-2:0]};
          ovf <= 1'b0;
          unf <= 1'b0;
          st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (ea == '0) begin
            z_out <= yw; st <= ST_FIN;
          end else if (eb == '0) begin
            z_out <= xw; st <= ST_FIN;
          end else begin
            st <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (al_same) begin
            st <= ST_ADD;
          end else if (al_lost) begin
            z_out <= al_a_small ? yw : xw;
            st <= ST_FIN;
          end else if (al_a_small) begin
            ma <= al_shifted; ea <= al_bumped;
          end else begin
            mb <= al_shifted; eb <= al_bumped;
          end
        end
        ST_ADD: begin
          rs <= ad_sign;
          if (ad_mag == '0) begin
            z_out <= '0; st <= ST_FIN;
          end else if (ad_mag[SW]) begin
            rsig <= ad_mag[SW:1];
            re   <= ea + EW'(1);
            if (ea + EW'(1) == EW'(EMAX)) begin
              ovf   <= 1'b1;
              z_out <= {ad_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
              st    <= ST_FIN;
            end else begin
              st <= ST_NORM;
            end
          end else begin
            rsig <= ad_mag[SW-1:0];
            re   <= ea;
            st   <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (rsig[SW-1]) begin
            st <= ST_ROUND;
          end else if (re == EW'(1)) begin
            unf   <= 1'b1;
            z_out <= {rs, {(WORD_W-1){1'b0}}};
            st    <= ST_FIN;
          end else begin
            rsig <= rsig << 1;
            re   <= re - EW'(1);
          end
        end
        ST_ROUND: begin
          z_out <= rp_word;
          ovf   <= rp_ovf;
          st    <= ST_FIN;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpas_checker.sv
module fpas_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    done,
  input logic                    ovf,
  input logic                    unf,
  input logic [EXP_W+FRAC_W-1:0] z_mag,
  input logic                    zero_hit,
  input logic                    norm_step,
  input logic [EXP_W:0]          re
);
  // R11: one-cycle completion pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11: flags exclusive
  a_r11_flag_excl: assert property (@(posedge clk) disable iff (!rst_n) !(ovf && unf));
  // R3: zero operand completes right after the check phase
  a_r3_zero_fast: assert property (@(posedge clk) disable iff (!rst_n) zero_hit |=> done);
  // R6: overflow reports the infinity pattern
  a_r6_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (z_mag[EXP_W+FRAC_W-1:FRAC_W] == '1) && (z_mag[FRAC_W-1:0] == '0));
  // R7: underflow reports a zero magnitude
  a_r7_unf_zero: assert property (@(posedge clk) disable iff (!rst_n) unf |-> (z_mag == '0));
  // R7: every normalisation shift lowers the exponent by one
  a_r7_norm_dec: assert property (@(posedge clk) disable iff (!rst_n)
    norm_step |=> (re == $past(re) - (EXP_W+1)'(1)));
endmodule

bind fp_addsub_seq fpas_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ovf(ovf), .unf(unf),
  .z_mag(z_out[EXP_W+FRAC_W-1:0]), .zero_hit(zero_hit),
  .norm_step(norm_step), .re(re)
);

// File: tb/test_fp_addsub_seq.sv
`timescale 1ns/1ps
module test_fp_addsub_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] x_in = '0, y_in = '0;
  logic [31:0] z_out;
  logic        done, ovf, unf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_addsub_seq i_fp_addsub_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .x_in(x_in), .y_in(y_in), .z_out(z_out), .done(done), .ovf(ovf), .unf(unf)
  );

  // reference: {ovf, unf, z}
  function automatic logic [33:0] ref_op(input logic [31:0] x, input logic [31:0] y, input bit sub);
    logic sx, sy, s;
    int ex, ey, e, d;
    longint mx, my, m, mant;
    sx = x[31]; sy = y[31] ^ sub;
    ex = int'(x[30:23]); ey = int'(y[30:23]);
    if (ex == 0) return {2'b00, sy, y[30:0]};
    if (ey == 0) return {2'b00, x};
    mx = (longint'(1 << 23) + longint'(x[22:0])) * 8;
    my = (longint'(1 << 23) + longint'(y[22:0])) * 8;
    if (ex >= ey) begin
      d = ex - ey;
      if (d >= 27) return {2'b00, x};
      my = my >> d; e = ex;
    end else begin
      d = ey - ex;
      if (d >= 27) return {2'b00, sy, y[30:0]};
      mx = mx >> d; e = ey;
    end
    if (sx == sy) begin m = mx + my; s = sx; end
    else if (mx >= my) begin m = mx - my; s = sx; end
    else begin m = my - mx; s = sy; end
    if (m == 0) return 34'd0;
    if (m >= (64'd1 << 27)) begin
      m = m >> 1; e = e + 1;
      if (e == 255) return {2'b10, s, 8'hFF, 23'd0};
    end
    while (m < (64'd1 << 26)) begin
      if (e == 1) return {2'b01, s, 31'd0};
      m = m * 2; e = e - 1;
    end
    mant = m >> 3;
    if (((m >> 2) & 1) == 1) mant = mant + 1;
    if (mant == (64'd1 << 24)) begin mant = 64'd1 << 23; e = e + 1; end
    if (e == 255) return {2'b10, s, 8'hFF, 23'd0};
    return {2'b00, s, 8'(e), 23'(mant)};
  endfunction

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got ovf=%0b unf=%0b z=%h, expected ovf=%0b unf=%0b z=%h",
               tag, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input bit sub,
                        output logic [33:0] res, output int lat);
    @(negedge clk);
    x_in = x; y_in = y; op_sub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11: no done pulse, got 0 expected 1");
    end
    res = {ovf, unf, z_out};
  endtask

  task automatic do_op(input string tag, input logic [31:0] x, input logic [31:0] y, input bit sub);
    logic [33:0] r;
    int lat;
    run_op(x, y, sub, r, lat);
    check(tag, r, ref_op(x, y, sub));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [33:0] r;
    int lat;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {ovf, unf, z_out}, 34'd0);
    checks++;
    if (done !== 1'b0) begin errors++; $display("FAIL R1: done got %0b expected 0", done); end
    rst_n = 1'b1;

    // R9: bias-127 encoding of 47.625
    run_op(32'h42200000, 32'h40F40000, 1'b0, r, lat);
    check("R9 47.625", r, {2'b00, 32'h423E8000});
    // R2: subtraction flips Y sign
    run_op(32'h42200000, 32'hC0F40000, 1'b1, r, lat);
    check("R2 sub of negative", r, {2'b00, 32'h423E8000});
    do_op("R2 random sub", 32'h40490FDB, 32'h402DF854, 1'b1);
    // R3: zero operands and latency
    run_op(32'h00000000, 32'h3FC00000, 1'b1, r, lat);
    check("R3 x zero", r, {2'b00, 32'hBFC00000});
    checks++;
    if (lat != 1) begin errors++; $display("FAIL R3: latency got %0d expected 1", lat); end
    run_op(32'hC1200000, 32'h00000000, 1'b0, r, lat);
    check("R3 y zero", r, {2'b00, 32'hC1200000});
    // R4: alignment loses the smaller operand
    run_op(32'h3F800000, 32'h32000000, 1'b0, r, lat);
    check("R4 gap 27 y lost", r, {2'b00, 32'h3F800000});
    run_op(32'h32000000, 32'h3F800000, 1'b1, r, lat);
    check("R4 gap 27 x lost", r, {2'b00, 32'hBF800000});
    do_op("R4 gap 26", 32'h3F800000, 32'h32800000, 1'b0);
    // R5: cancellation gives +0
    run_op(32'hC0A00000, 32'hC0A00000, 1'b1, r, lat);
    check("R5 cancel", r, 34'd0);
    run_op(32'h40400000, 32'hBF800000, 1'b0, r, lat);
    check("R5 mixed signs", r, {2'b00, 32'h40000000});
    // R6: overflow
    run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, r, lat);
    check("R6 overflow", r, {2'b10, 32'h7F800000});
    run_op(32'h3F800000, 32'h3F800000, 1'b0, r, lat);
    check("R6 carry shift", r, {2'b00, 32'h40000000});
    // R7: underflow stop
    run_op(32'h01400000, 32'h01200000, 1'b1, r, lat);
    check("R7 underflow", r, {2'b01, 32'h00000000});
    do_op("R7 long normalise", 32'h3F800001, 32'h3F800000, 1'b1);
    // R8: rounding
    run_op(32'h3F800000, 32'h33800000, 1'b0, r, lat);
    check("R8 half rounds up", r, {2'b00, 32'h3F800001});
    run_op(32'h3F800000, 32'h33000000, 1'b0, r, lat);
    check("R8 below half", r, {2'b00, 32'h3F800000});
    run_op(32'h3FFFFFFF, 32'h33800000, 1'b0, r, lat);
    check("R8 rounding carry", r, {2'b00, 32'h40000000});

    // R10: start while busy is ignored
    @(negedge clk);
    x_in = 32'h3F800000; y_in = 32'h36000000; op_sub = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    x_in = 32'h00000000; y_in = 32'h40000000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    check("R10 busy start ignored", {ovf, unf, z_out}, ref_op(32'h3F800000, 32'h36000000, 1'b0));
    // R11: single pulse, no further done
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin errors++; $display("FAIL R11: done got %0b expected 0", done); end
    lat = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (done) lat++; end
    checks++;
    if (lat != 0) begin errors++; $display("FAIL R10: extra done pulses got %0d expected 0", lat); end

    // random mix (R5, R2, R11)
    for (int n = 0; n < 300; n++) begin
      int ex, ey;
      logic [31:0] x, y;
      ex = 1 + int'($urandom % 254);
      if ($urandom % 4 == 0) ey = 1 + int'($urandom % 254);
      else begin
        ey = ex + int'($urandom % 13) - 6;
        if (ey < 1) ey = 1;
        if (ey > 254) ey = 254;
      end
      x = {1'($urandom), 8'(ex), 23'($urandom)};
      y = {1'($urandom), 8'(ey), 23'($urandom)};
      if ($urandom % 10 == 0) y[30:0] = x[30:0];
      run_op(x, y, 1'($urandom), r, lat);
      check("R5 random", r, ref_op(x, y, op_sub));
      checks++;
      if (r[33] && r[32]) begin errors++; $display("FAIL R11: flags got 11 expected not both"); end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule